// File: doc/BRIEF.md
# Criticality-Aware Victim Selector

This block picks which way of a set-associative cache is evicted on a miss. It keeps per-line state for every way of every set: a valid bit, a critical bit and a true-LRU recency age. When a miss is presented, it steers eviction toward ordinary lines. This lets lines from protected address ranges stay resident longer than plain recency alone would allow.

A line counts as critical when its fill address falls inside one of a few address windows that software programs through a small register write port. Each window has a base, an inclusive limit and an enable. The critical bit is decided once, when the line is filled. Among valid lines, the victim is the oldest line that is not critical. If a set holds no critical lines, or holds only critical lines, selection is plain LRU. Empty ways always go first.

The surrounding cache controller drives one access per cycle, either a hit on a known way or a miss that fills the returned victim. Tag and data arrays, the bus and the pipeline stay outside the block.

Top module: `crit_victim_sel`

## Requirements
- R1: When the addressed set has at least one invalid way, the victim is the lowest-numbered invalid way, whatever the critical bits say.
- R2: When every way of the set is valid and both critical and non-critical lines are present, the victim is the oldest (least recently used) way among the non-critical ones.
- R3: When every way of the set is valid and none is critical, the victim is the least recently used way of the set.
- R4: When every way of the set is valid and all are critical, the victim is the least recently used way of the set.
- R5: A filled line is critical exactly when, for some enabled window, base <= fill address <= limit; both ends are inclusive, and disabled windows never match.
- R6: The critical bit is stored when the line is filled; later window writes do not change the bits of lines already present.
- R7: A hit or a fill makes the touched way the most recent. Ways that were more recent than it become one step older, and the order among all other ways is unchanged.
- R8: The victim is combinational from the current state of acc_set and is valid in the cycle of the miss. On a miss (acc_valid=1, acc_hit=0) the victim way is filled and marked valid at the next rising edge. A window write in the same cycle as a fill takes effect only after that edge, so it does not affect the fill's critical bit.
- R9: Synchronous reset (rst=1) leaves every line invalid and non-critical, disables every window, and sets the ages to way order, with way 0 most recent and the highest way oldest.
- R10: When cfg_we=1, cfg_field selects the field of window cfg_idx that is written: 0 writes the base, 1 writes the limit, 2 writes the enable from cfg_wdata bit 0, and 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access (hit or miss) is presented this cycle |
| acc_set | input | 4 | Set index of the access |
| acc_hit | input | 1 | 1 = hit on acc_hit_way, 0 = miss filled into victim_way |
| acc_hit_way | input | 2 | Way that hit |
| acc_addr | input | 32 | Fill address, used on a miss to decide criticality |
| victim_way | output | 2 | Way to evict in set acc_set |
| cfg_we | input | 1 | Window register write strobe |
| cfg_idx | input | 2 | Window number |
| cfg_field | input | 2 | 0 base, 1 limit, 2 enable, 3 none |
| cfg_wdata | input | 32 | Write data (bit 0 for enable) |

## Verification
The bench uses the default build: 4 ways, 16 sets, 4 windows and 32-bit addresses. With only 16 sets, random traffic fills sets completely and keeps revisiting them, so the mixed, all-critical and no-critical selection paths all occur many times. Four ways are few enough that directed fills can place critical lines at chosen ages. Full 32-bit windows let fills land exactly on a base, on a limit, and one address outside each.

// File: rtl/crit_victim_pkg.sv
package crit_victim_pkg;

    // Field selector for the window register write port.
    typedef enum logic [1:0] {
        CFG_BASE   = 2'd0,
        CFG_LIMIT  = 2'd1,
        CFG_ENABLE = 2'd2,
        CFG_NONE   = 2'd3
    } cfg_field_e;

endpackage

// File: rtl/crit_range_match.sv
module crit_range_match #(
    parameter int NRANGE = 4,
    parameter int AW     = 32
) (
    input  logic [NRANGE-1:0][AW-1:0] win_base,
    input  logic [NRANGE-1:0][AW-1:0] win_limit,
    input  logic [NRANGE-1:0]         win_en,
    input  logic [AW-1:0]             addr,
    output logic                      in_window
);

    logic [NRANGE-1:0] hit_r;

    for (genvar r = 0; r < NRANGE; r++) begin : g_win
        assign hit_r[r] = win_en[r] && (addr >= win_base[r]) && (addr <= win_limit[r]);
    end

    assign in_window = |hit_r;

endmodule

// File: rtl/crit_lc_select.sv
module crit_lc_select #(
    parameter int WAYS = 4,
    localparam int WIDX = $clog2(WAYS),
    localparam int AGEW = WIDX
) (
    input  logic [WAYS-1:0]           way_valid,
    input  logic [WAYS-1:0]           way_crit,
    input  logic [WAYS-1:0][AGEW-1:0] way_age,
    output logic [WIDX-1:0]           victim
);

    logic            have_inv;
    logic            found;
    logic [WAYS-1:0] pool;
    logic [AGEW-1:0] best_age;

    always_comb begin
        victim   = '0;
        have_inv = 1'b0;
        found    = 1'b0;
        best_age = '0;
        // Lowest invalid way wins outright.
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w]) begin
                victim   = WIDX'(w);
                have_inv = 1'b1;
            end
        end
        // Candidate pool: the non-critical ways, or every way when that set is empty.
        pool = ~way_crit;
        if (pool == '0) begin
            pool = '1;
        end
        if (!have_inv) begin
            for (int w = 0; w < WAYS; w++) begin
                if (pool[w] && (!found || (way_age[w] > best_age))) begin
                    found    = 1'b1;
                    best_age = way_age[w];
                    victim   = WIDX'(w);
                end
            end
        end
    end

endmodule

// File: rtl/crit_lru_touch.sv
module crit_lru_touch #(
    parameter int WAYS = 4,
    localparam int WIDX = $clog2(WAYS),
    localparam int AGEW = WIDX
) (
    input  logic [WAYS-1:0][AGEW-1:0] age_in,
    input  logic [WIDX-1:0]           target,
    output logic [WAYS-1:0][AGEW-1:0] age_out
);

    logic [AGEW-1:0] old_age;

    assign old_age = age_in[target];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        always_comb begin
            if (WIDX'(w) == target) begin
                age_out[w] = '0;
            end else if (age_in[w] < old_age) begin
                age_out[w] = age_in[w] + AGEW'(1);
            end else begin
                age_out[w] = age_in[w];
            end
        end
    end

endmodule

// File: rtl/crit_victim_sel.sv
module crit_victim_sel
    import crit_victim_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    parameter int NRANGE = 4,
    parameter int AW     = 32,
    localparam int WIDX  = $clog2(WAYS),
    localparam int SIDX  = $clog2(SETS),
    localparam int RIDX  = $clog2(NRANGE),
    localparam int AGEW  = WIDX
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            acc_valid,
    input  logic [SIDX-1:0] acc_set,
    input  logic            acc_hit,
    input  logic [WIDX-1:0] acc_hit_way,
    input  logic [AW-1:0]   acc_addr,
    output logic [WIDX-1:0] victim_way,
    input  logic            cfg_we,
    input  logic [RIDX-1:0] cfg_idx,
    input  logic [1:0]      cfg_field,
    input  logic [AW-1:0]   cfg_wdata
);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]           valid;
        logic [SETS-1:0][WAYS-1:0]           crit;
        logic [SETS-1:0][WAYS-1:0][AGEW-1:0] age;
        logic [NRANGE-1:0][AW-1:0]           base;
        logic [NRANGE-1:0][AW-1:0]           limit;
        logic [NRANGE-1:0]                   en;
    } state_t;

    state_t st_d;
    state_t st_q;
    state_t st_rst;

    logic                      fill_crit_d;
    logic [WIDX-1:0]           target_d;
    logic [WAYS-1:0][AGEW-1:0] aged_d;

    // Views of the state for the bound checker.
    logic [SETS-1:0][WAYS-1:0]           valid_q;
    logic [SETS-1:0][WAYS-1:0]           crit_q;
    logic [SETS-1:0][WAYS-1:0][AGEW-1:0] age_q;
    logic [NRANGE-1:0]                   en_q;

    assign valid_q = st_q.valid;
    assign crit_q  = st_q.crit;
    assign age_q   = st_q.age;
    assign en_q    = st_q.en;

    crit_range_match #(.NRANGE(NRANGE), .AW(AW)) u_match (
        .win_base  (st_q.base),
        .win_limit (st_q.limit),
        .win_en    (st_q.en),
        .addr      (acc_addr),
        .in_window (fill_crit_d)
    );

    crit_lc_select #(.WAYS(WAYS)) u_select (
        .way_valid (st_q.valid[acc_set]),
        .way_crit  (st_q.crit[acc_set]),
        .way_age   (st_q.age[acc_set]),
        .victim    (victim_way)
    );

    assign target_d = acc_hit ? acc_hit_way : victim_way;

    crit_lru_touch #(.WAYS(WAYS)) u_touch (
        .age_in  (st_q.age[acc_set]),
        .target  (target_d),
        .age_out (aged_d)
    );

    // Reset image: everything clear, ages in way order.
    always_comb begin
        st_rst = '0;
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                st_rst.age[s][w] = AGEW'(w);
            end
        end
    end

    // Next-state computation.
    always_comb begin
        st_d = st_q;
        if (acc_valid) begin
            st_d.age[acc_set] = aged_d;
            if (!acc_hit) begin
                st_d.valid[acc_set][target_d] = 1'b1;
                st_d.crit[acc_set][target_d]  = fill_crit_d;
            end
        end
        if (cfg_we) begin
            case (cfg_field_e'(cfg_field))
                CFG_BASE:   st_d.base[cfg_idx]  = cfg_wdata;
                CFG_LIMIT:  st_d.limit[cfg_idx] = cfg_wdata;
                CFG_ENABLE: st_d.en[cfg_idx]    = cfg_wdata[0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/crit_victim_sel_chk.sv
module crit_victim_sel_chk
    import crit_victim_pkg::*;
#(
    parameter int WAYS   = 4,
    parameter int SETS   = 16,
    parameter int NRANGE = 4,
    localparam int WIDX  = $clog2(WAYS),
    localparam int SIDX  = $clog2(SETS),
    localparam int RIDX  = $clog2(NRANGE),
    localparam int AGEW  = WIDX
) (
    input logic                                clk,
    input logic                                rst,
    input logic                                acc_valid,
    input logic [SIDX-1:0]                     acc_set,
    input logic                                acc_hit,
    input logic [WIDX-1:0]                     acc_hit_way,
    input logic [WIDX-1:0]                     victim_way,
    input logic                                cfg_we,
    input logic [RIDX-1:0]                     cfg_idx,
    input logic [1:0]                          cfg_field,
    input logic                                cfg_en_bit,
    input logic [SETS-1:0][WAYS-1:0]           valid_q,
    input logic [SETS-1:0][WAYS-1:0]           crit_q,
    input logic [SETS-1:0][WAYS-1:0][AGEW-1:0] age_q,
    input logic [NRANGE-1:0]                   en_q
);

    logic [WAYS-1:0] seen_age;

    always_comb begin
        seen_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            seen_age[age_q[acc_set][w]] = 1'b1;
        end
    end

    p_invalid_first_r1: assert property (@(posedge clk) disable iff (rst)
        (~&valid_q[acc_set]) |-> !valid_q[acc_set][victim_way]);

    p_spare_critical_r2: assert property (@(posedge clk) disable iff (rst)
        ((&valid_q[acc_set]) && (|(~crit_q[acc_set]))) |-> !crit_q[acc_set][victim_way]);

    p_hit_mru_r7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_hit) |=> (age_q[$past(acc_set)][$past(acc_hit_way)] == '0));

    p_age_perm_r7: assert property (@(posedge clk) disable iff (rst)
        seen_age == '1);

    p_fill_valid_r8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_hit) |=> valid_q[$past(acc_set)][$past(victim_way)]);

    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (valid_q == '0 && crit_q == '0 && en_q == '0));

    p_enable_write_r10: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_field == CFG_ENABLE) |=> (en_q[$past(cfg_idx)] == $past(cfg_en_bit)));

endmodule

bind crit_victim_sel crit_victim_sel_chk #(
    .WAYS   (WAYS),
    .SETS   (SETS),
    .NRANGE (NRANGE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_valid   (acc_valid),
    .acc_set     (acc_set),
    .acc_hit     (acc_hit),
    .acc_hit_way (acc_hit_way),
    .victim_way  (victim_way),
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .cfg_field   (cfg_field),
    .cfg_en_bit  (cfg_wdata[0]),
    .valid_q     (valid_q),
    .crit_q      (crit_q),
    .age_q       (age_q),
    .en_q        (en_q)
);

// File: tb/crit_victim_sel_tb.sv
module crit_victim_sel_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [3:0]  acc_set;
    logic        acc_hit;
    logic [1:0]  acc_hit_way;
    logic [31:0] acc_addr;
    logic [1:0]  victim_way;
    logic        cfg_we;
    logic [1:0]  cfg_idx;
    logic [1:0]  cfg_field;
    logic [31:0] cfg_wdata;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    crit_victim_sel u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_hit_way(acc_hit_way), .acc_addr(acc_addr),
        .victim_way(victim_way), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata)
    );

    // Behavioural reference: per-set recency list, front = most recent.
    int          order [16][$];
    bit          m_valid [16][4];
    bit          m_crit [16][4];
    logic [31:0] m_base [4];
    logic [31:0] m_limit [4];
    bit          m_en [4];

    function automatic void model_reset();
        for (int s = 0; s < 16; s++) begin
            order[s].delete();
            for (int w = 0; w < 4; w++) begin
                order[s].push_back(w);
                m_valid[s][w] = 0;
                m_crit[s][w]  = 0;
            end
        end
        for (int r = 0; r < 4; r++) begin
            m_en[r] = 0; m_base[r] = 0; m_limit[r] = 0;
        end
    endfunction

    function automatic bit model_is_crit(logic [31:0] a);
        for (int r = 0; r < 4; r++)
            if (m_en[r] && a >= m_base[r] && a <= m_limit[r]) return 1;
        return 0;
    endfunction

    function automatic int model_victim(int s);
        int ncrit = 0;
        for (int w = 0; w < 4; w++) if (!m_valid[s][w]) return w;
        for (int w = 0; w < 4; w++) if (m_crit[s][w]) ncrit++;
        if (ncrit == 0 || ncrit == 4) return order[s][order[s].size() - 1];
        for (int i = order[s].size() - 1; i >= 0; i--)
            if (!m_crit[s][order[s][i]]) return order[s][i];
        return -1;
    endfunction

    function automatic void model_touch(int s, int w);
        for (int i = 0; i < order[s].size(); i++) begin
            if (order[s][i] == w) begin
                order[s].delete(i);
                break;
            end
        end
        order[s].push_front(w);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s victim actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare, then advance model past the rising edge.
    task automatic cyc(input bit av, input bit hit, input int hw, input int s,
                       input logic [31:0] addr, input bit we, input int idx,
                       input int fld, input logic [31:0] wd, input string req,
                       input int lit = -1);
        int mv;
        acc_valid = av; acc_hit = hit; acc_hit_way = 2'(hw); acc_set = 4'(s);
        acc_addr = addr; cfg_we = we; cfg_idx = 2'(idx); cfg_field = 2'(fld);
        cfg_wdata = wd;
        #2;
        mv = model_victim(s);
        check(req, int'(victim_way), mv);
        if (lit >= 0) check(req, int'(victim_way), lit);
        @(posedge clk);
        if (av) begin
            if (hit) model_touch(s, hw);
            else begin
                m_valid[s][mv] = 1;
                m_crit[s][mv]  = model_is_crit(addr);
                model_touch(s, mv);
            end
        end
        if (we) begin
            case (fld)
                0: m_base[idx]  = wd;
                1: m_limit[idx] = wd;
                2: m_en[idx]    = wd[0];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic idle(input int s, input string req, input int lit = -1);
        cyc(0, 0, 0, s, 32'h0, 0, 0, 0, 32'h0, req, lit);
    endtask

    task automatic fill(input int s, input logic [31:0] a, input string req, input int lit = -1);
        cyc(1, 0, 0, s, a, 0, 0, 0, 32'h0, req, lit);
    endtask

    task automatic hit_on(input int s, input int w, input string req);
        cyc(1, 1, w, s, 32'h0, 0, 0, 0, 32'h0, req);
    endtask

    task automatic wr(input int idx, input int fld, input logic [31:0] d, input string req);
        cyc(0, 0, 0, 0, 32'h0, 1, idx, fld, d, req);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; acc_valid = 0; acc_set = 0; acc_hit = 0; acc_hit_way = 0;
        acc_addr = 0; cfg_we = 0; cfg_idx = 0; cfg_field = 0; cfg_wdata = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_reset();

        // R9: after reset every set is empty, so way 0 is offered.
        for (int s = 0; s < 16; s++) idle(s, "R9", 0);

        // R1: empty ways are taken lowest first.
        fill(0, 32'h100, "R1", 0);
        fill(0, 32'h200, "R1", 1);
        fill(0, 32'h300, "R1", 2);
        fill(0, 32'h400, "R1", 3);
        // R3: no critical lines, plain LRU (way 0 oldest, then way 1 after a hit on 0).
        idle(0, "R3", 0);
        hit_on(0, 0, "R7");
        idle(0, "R3", 1);
        hit_on(0, 2, "R7");
        idle(0, "R3", 1);

        // R10: program window 0 = [0x1000, 0x1FFF], enabled.
        wr(0, 0, 32'h1000, "R10");
        wr(0, 1, 32'h1FFF, "R10");
        wr(0, 2, 32'h1, "R10");
        // R10: field 3 must not disturb window 0.
        wr(0, 3, 32'h0, "R10");
        // R5: edge addresses into set 1: 0x0FFF no, 0x1000 yes, 0x1FFF yes, 0x2000 no.
        fill(1, 32'h0FFF, "R5", 0);
        fill(1, 32'h1000, "R5", 1);
        fill(1, 32'h1FFF, "R5", 2);
        fill(1, 32'h2000, "R5", 3);
        idle(1, "R2", 0);
        hit_on(1, 0, "R7");
        // R2: LRU is way 1 (critical); oldest non-critical is way 3.
        idle(1, "R2", 3);
        hit_on(1, 3, "R7");
        idle(1, "R2", 0);

        // R4: all-critical set behaves as LRU.
        fill(2, 32'h1100, "R4", 0);
        fill(2, 32'h1200, "R4", 1);
        fill(2, 32'h1300, "R4", 2);
        fill(2, 32'h1400, "R4", 3);
        idle(2, "R4", 0);
        hit_on(2, 0, "R4");
        idle(2, "R4", 1);

        // R6: ordinary lines in set 3, then a window covering them.
        fill(3, 32'h5000, "R6", 0);
        fill(3, 32'h5100, "R6", 1);
        fill(3, 32'h5200, "R6", 2);
        fill(3, 32'h5300, "R6", 3);
        hit_on(3, 0, "R6");
        wr(1, 0, 32'h5000, "R6");
        wr(1, 1, 32'h5FFF, "R6");
        wr(1, 2, 32'h1, "R6");
        idle(3, "R6", 1);
        // Disabling window 0 leaves set 1's critical lines as they were.
        wr(0, 2, 32'h0, "R6");
        idle(1, "R6", 0);
        hit_on(1, 0, "R6");
        idle(1, "R6", 3);

        // R8: window write in the same cycle as a fill uses the old windows.
        wr(2, 0, 32'h9000, "R8");
        wr(2, 1, 32'h9FFF, "R8");
        cyc(1, 0, 0, 4, 32'h9800, 1, 2, 2, 32'h1, "R8", 0);
        fill(4, 32'h9800, "R8", 1);
        fill(4, 32'h9900, "R8", 2);
        fill(4, 32'h9A00, "R8", 3);
        // Way 0 stayed non-critical, so it is the victim even though it is oldest among mixed lines.
        idle(4, "R8", 0);
        hit_on(4, 0, "R8");
        idle(4, "R8", 0);

        // Mixed random traffic against the reference model.
        for (int i = 0; i < 3000; i++) begin
            int s;
            int w;
            int pick;
            logic [31:0] a;
            s = int'($urandom_range(0, 15));
            w = int'($urandom_range(0, 3));
            a = 32'($urandom_range(0, 16'hBFFF));
            pick = int'($urandom_range(0, 99));
            if (pick < 5)
                cyc(0, 0, 0, s, a, 1, int'($urandom_range(0, 3)),
                    int'($urandom_range(0, 3)), 32'($urandom_range(0, 16'hBFFF)), "R2");
            else if (pick < 55 && m_valid[s][w])
                hit_on(s, w, "R7");
            else if (pick < 90)
                fill(s, a, "R2");
            else
                idle(s, "R3");
        end

        summary();
        $finish;
    end

endmodule